// File: doc/BRIEF.md
# Bus-Master Popup Idle-State Sequencer

This block sequences the processor idle level of a chipset power manager. It holds the present level (C0, C2, C3 or C4) and reacts to bus-master requests from two groups of sources: a main group (PCI, PCI Express and internal masters) and an LPC group (LPC DMA and LPC masters). A request that arrives while the processor sits in C3 or C4 can either break the idle period and return to C0, or, when popup is enabled, raise the system only to C2 with bus-master arbitration turned on so that snoops and memory traffic can be served. Once the bus has been quiet for a set number of cycles, a popdown takes the system back to the deep level it left.

An 8-bit configuration byte selects popup, popdown and suppression of the bus-master status flag, and carries a two-bit scratchpad. The sticky status flag records bus-master activity and is cleared by a software write of one. The operating system requests idle levels through a plain command strobe; an external wake event always returns the system to C0.

All pins are plain control and status signals; there is no streaming interface, so no valid/ready back-pressure applies.

Top module: `bm_popup_ctrl`

## Requirements
- R1: The configuration byte resets to 00h. Bit 3 is popup enable, bit 2 popdown enable, bit 4 status suppress, bits 6:5 a scratchpad; bits 7 and 1:0 always read 0. A write takes effect from the next clock edge.
- R2: With popup enable 0, any bus-master request while in C3 or C4 moves the level to C0 at the next edge and turns arbitration enable on.
- R3: With popup enable 1, any bus-master request while in C3 or C4 moves the level to C2 at the next edge, turns arbitration enable on and records the deep level that was left.
- R4: In a popped-up C2 with effective popdown on, after IDLE_CYCLES consecutive request-free cycles the level returns to the recorded C3 or C4 at the edge that samples the last of those cycles, and arbitration enable goes off. Arbitration enable is off whenever the level is C3 or C4.
- R5: Popdown enable acts as 0 while popup enable is 0: a popped-up C2 then stays in C2 however long the bus is idle.
- R6: Popup with popdown disabled is legal: the level stays in C2 after a popup while the bus is idle.
- R7: Any request during a popped-up C2 restarts the idle count from zero.
- R8: With suppress 0, main-group activity sets the status flag at the next edge; with suppress 1 it does not.
- R9: LPC-group activity sets the status flag at the next edge regardless of suppress.
- R10: The status flag stays set until a clear strobe; setting suppress does not clear it; a set and a clear in the same cycle leave it set.
- R11: A wake event moves the level to C0 at the next edge from any level, with arbitration on, taking priority over a bus-master request.
- R12: The idle-level command (C0=0, C2=1, C3=2, C4=3) is accepted only from C0 or C2 and is ignored in C3 and C4; entering C3 or C4 by command turns arbitration off.
- R13: After reset the level is C0, arbitration enable is 1 and the status flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_data | input | 8 | Configuration byte write value |
| cfg_rd_data | output | 8 | Configuration byte read value |
| bm_sts_clr | input | 1 | Software wrote 1 to the status flag |
| bm_sts | output | 1 | Sticky bus-master status flag |
| bm_req_main | input | N_MAIN | Requests from PCI, PCI Express and internal masters |
| bm_req_lpc | input | N_LPC | Requests from LPC DMA and LPC masters |
| wake_evt | input | 1 | Break event forcing return to C0 |
| sleep_cmd_valid | input | 1 | Idle-level command strobe |
| sleep_cmd_state | input | 2 | Commanded level (0=C0, 1=C2, 2=C3, 3=C4) |
| cstate | output | 2 | Present idle level (0=C0, 1=C2, 2=C3, 3=C4) |
| bm_arb_en | output | 1 | Bus-master arbitration enable |

## Verification
Every result is registered: level, arbitration enable and status flag change at the first clock edge after the cycle that presents the stimulus, and a configuration write shows on the read port after that same edge. The bench drives inputs on the falling edge and compares on the following falling edge, so each comparison lands exactly one rising edge after its stimulus. The popdown is due at the edge that samples the IDLE_CYCLES-th quiet cycle; the bench builds the IDLE_CYCLES quiet rows explicitly and checks both the row before (still C2) and the row of the drop.

// File: rtl/bm_popup_pkg.sv
package bm_popup_pkg;

  typedef enum logic [1:0] {
    LVL_C0 = 2'd0,
    LVL_C2 = 2'd1,
    LVL_C3 = 2'd2,
    LVL_C4 = 2'd3
  } lvl_e;

  localparam int unsigned CFG_W        = 8;
  localparam int unsigned CFG_DROP_BIT = 2;
  localparam int unsigned CFG_POP_BIT  = 3;
  localparam int unsigned CFG_QUIET_BIT = 4;
  localparam logic [CFG_W-1:0] CFG_WR_MASK = 8'h7C;

  function automatic logic lvl_is_deep(input lvl_e l);
    return (l == LVL_C3) || (l == LVL_C4);
  endfunction

endpackage

// File: rtl/bm_cfg_reg.sv
module bm_cfg_reg
  import bm_popup_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             pop_en,
  output logic             drop_en,
  output logic             quiet
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & CFG_WR_MASK;
  end

  assign rd_data = cfg_q;
  assign pop_en  = cfg_q[CFG_POP_BIT];
  // popdown has no effect unless popup is on
  assign drop_en = cfg_q[CFG_DROP_BIT] & cfg_q[CFG_POP_BIT];
  assign quiet   = cfg_q[CFG_QUIET_BIT];

endmodule

// File: rtl/bm_status_flag.sv
module bm_status_flag #(
  parameter int unsigned N_MAIN = 3,
  parameter int unsigned N_LPC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MAIN-1:0] main_act,
  input  logic [N_LPC-1:0]  lpc_act,
  input  logic              quiet,
  input  logic              clr,
  output logic              sts
);

  logic set_evt;

  // LPC activity always records; main activity only when not suppressed
  assign set_evt = (|lpc_act) | ((|main_act) & ~quiet);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts <= 1'b0;
    else if (set_evt) sts <= 1'b1;
    else if (clr)     sts <= 1'b0;
  end

endmodule

// File: rtl/bm_idle_timer.sv
module bm_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic busy,
  output logic expired
);

  localparam int unsigned CW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired = arm & ~busy & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!arm || busy)   cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bm_level_fsm.sv
module bm_level_fsm
  import bm_popup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic any_req,
  input  logic pop_en,
  input  logic drop_en,
  input  logic idle_expired,
  input  logic cmd_valid,
  input  lvl_e cmd_lvl,
  output lvl_e lvl,
  output logic popped,
  output logic arb_en
);

  lvl_e lvl_q, lvl_d, rec_q, rec_d;
  logic pop_q, pop_d, arb_q, arb_d;

  always_comb begin
    lvl_d = lvl_q;
    rec_d = rec_q;
    pop_d = pop_q;
    arb_d = arb_q;
    if (wake) begin
      lvl_d = LVL_C0;
      rec_d = LVL_C0;
      pop_d = 1'b0;
      arb_d = 1'b1;
    end else if (lvl_is_deep(lvl_q) && any_req) begin
      arb_d = 1'b1;
      if (pop_en) begin
        lvl_d = LVL_C2;
        rec_d = lvl_q;
        pop_d = 1'b1;
      end else begin
        lvl_d = LVL_C0;
        rec_d = LVL_C0;
        pop_d = 1'b0;
      end
    end else if (pop_q && lvl_q == LVL_C2 && drop_en && idle_expired) begin
      lvl_d = rec_q;
      pop_d = 1'b0;
      arb_d = 1'b0;
    end else if (cmd_valid && !lvl_is_deep(lvl_q)) begin
      lvl_d = cmd_lvl;
      pop_d = 1'b0;
      arb_d = !lvl_is_deep(cmd_lvl);
      if (cmd_lvl == LVL_C0) rec_d = LVL_C0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_C0;
      rec_q <= LVL_C0;
      pop_q <= 1'b0;
      arb_q <= 1'b1;
    end else begin
      lvl_q <= lvl_d;
      rec_q <= rec_d;
      pop_q <= pop_d;
      arb_q <= arb_d;
    end
  end

  assign lvl    = lvl_q;
  assign popped = pop_q;
  assign arb_en = arb_q;

endmodule

// File: rtl/bm_popup_ctrl.sv
module bm_popup_ctrl
  import bm_popup_pkg::*;
#(
  parameter int unsigned N_MAIN      = 3,
  parameter int unsigned N_LPC       = 2,
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  output logic [7:0]        cfg_rd_data,
  input  logic              bm_sts_clr,
  output logic              bm_sts,
  input  logic [N_MAIN-1:0] bm_req_main,
  input  logic [N_LPC-1:0]  bm_req_lpc,
  input  logic              wake_evt,
  input  logic              sleep_cmd_valid,
  input  logic [1:0]        sleep_cmd_state,
  output logic [1:0]        cstate,
  output logic              bm_arb_en
);

  logic pop_en, drop_en, quiet, any_req, popped, idle_expired;
  lvl_e lvl;

  assign any_req = (|bm_req_main) | (|bm_req_lpc);

  bm_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .pop_en  (pop_en),
    .drop_en (drop_en),
    .quiet   (quiet)
  );

  bm_status_flag #(.N_MAIN(N_MAIN), .N_LPC(N_LPC)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .main_act (bm_req_main),
    .lpc_act  (bm_req_lpc),
    .quiet    (quiet),
    .clr      (bm_sts_clr),
    .sts      (bm_sts)
  );

  bm_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (popped && (lvl == LVL_C2)),
    .busy    (any_req),
    .expired (idle_expired)
  );

  bm_level_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake         (wake_evt),
    .any_req      (any_req),
    .pop_en       (pop_en),
    .drop_en      (drop_en),
    .idle_expired (idle_expired),
    .cmd_valid    (sleep_cmd_valid),
    .cmd_lvl      (lvl_e'(sleep_cmd_state)),
    .lvl          (lvl),
    .popped       (popped),
    .arb_en       (bm_arb_en)
  );

  assign cstate = lvl;

endmodule

// File: rtl/bm_popup_ctrl_chk.sv
module bm_popup_ctrl_chk #(
  parameter int unsigned N_MAIN = 3,
  parameter int unsigned N_LPC  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rd_data,
  input logic              bm_sts_clr,
  input logic              bm_sts,
  input logic [N_MAIN-1:0] bm_req_main,
  input logic [N_LPC-1:0]  bm_req_lpc,
  input logic              wake_evt,
  input logic              sleep_cmd_valid,
  input logic [1:0]        cstate,
  input logic              bm_arb_en
);

  logic req, deep, pop;
  assign req  = (|bm_req_main) | (|bm_req_lpc);
  assign deep = cstate[1];
  assign pop  = cfg_rd_data[3];

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[7] == 1'b0) && (cfg_rd_data[1:0] == 2'b00));

  p_break_c0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && req && !wake_evt && !pop) |=> (cstate == 2'd0) && bm_arb_en);

  p_popup_c2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && req && !wake_evt && pop) |=> (cstate == 2'd1) && bm_arb_en);

  p_arb_off_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> !bm_arb_en);

  p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate == 2'd1 && !pop && !sleep_cmd_valid) |=> !cstate[1]);

  p_lpc_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|bm_req_lpc) |=> bm_sts);

  p_sts_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_sts && !bm_sts_clr) |=> bm_sts);

  p_wake_c0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (cstate == 2'd0) && bm_arb_en);

  p_deep_cmd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && sleep_cmd_valid && !wake_evt && !req) |=> $stable(cstate));

endmodule

bind bm_popup_ctrl bm_popup_ctrl_chk #(.N_MAIN(N_MAIN), .N_LPC(N_LPC)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_rd_data     (cfg_rd_data),
  .bm_sts_clr      (bm_sts_clr),
  .bm_sts          (bm_sts),
  .bm_req_main     (bm_req_main),
  .bm_req_lpc      (bm_req_lpc),
  .wake_evt        (wake_evt),
  .sleep_cmd_valid (sleep_cmd_valid),
  .cstate          (cstate),
  .bm_arb_en       (bm_arb_en)
);

// File: tb/bm_popup_ctrl_test.sv
module bm_popup_ctrl_test;

  localparam int unsigned N_MAIN = 3;
  localparam int unsigned N_LPC  = 2;
  localparam int unsigned IDLE   = 4;
  localparam int unsigned NROWS  = 41;

  typedef struct packed {
    logic       cw;
    logic [7:0] cd;
    logic       cv;
    logic [1:0] cs;
    logic       wk;
    logic [2:0] mn;
    logic [1:0] lp;
    logic       cl;
    logic [1:0] es;
    logic       ea;
    logic       et;
    logic [23:0] tag;
  } vec_t;

  function automatic vec_t mk(input logic cw, input logic [7:0] cd, input logic cv,
                              input logic [1:0] cs, input logic wk, input logic [2:0] mn,
                              input logic [1:0] lp, input logic cl, input logic [1:0] es,
                              input logic ea, input logic et, input logic [23:0] tag);
    return '{cw, cd, cv, cs, wk, mn, lp, cl, es, ea, et, tag};
  endfunction

  // levels: 0=C0 1=C2 2=C3 3=C4 ; cfg: 08h popup, 04h popdown, 10h suppress
  localparam vec_t TBL [NROWS] = '{
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 0,1,0, "R13"), // 0 idle at reset
    mk(0,8'h00,1,2,0,3'b000,2'b00,0, 2,0,0, "R12"), // 1 enter C3
    mk(0,8'h00,0,0,0,3'b001,2'b00,0, 0,1,1, "R2 "), // 2 break to C0, sts set (R8)
    mk(0,8'h00,0,0,0,3'b000,2'b00,1, 0,1,0, "R10"), // 3 clear
    mk(1,8'h0C,0,0,0,3'b000,2'b00,0, 0,1,0, "R1 "), // 4 popup+popdown
    mk(0,8'h00,1,3,0,3'b000,2'b00,0, 3,0,0, "R12"), // 5 enter C4
    mk(0,8'h00,1,1,0,3'b000,2'b00,0, 3,0,0, "R12"), // 6 command ignored in C4
    mk(0,8'h00,0,0,0,3'b000,2'b01,0, 1,1,1, "R3 "), // 7 popup via LPC (R9)
    mk(0,8'h00,0,0,0,3'b000,2'b00,1, 1,1,0, "R4 "), // 8 idle 1
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R4 "), // 9 idle 2
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R4 "), // 10 idle 3
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 3,0,0, "R4 "), // 11 idle 4 -> back to C4
    mk(0,8'h00,0,0,0,3'b100,2'b00,0, 1,1,1, "R8 "), // 12 popup, main sets sts
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,1, "R7 "), // 13 idle 1
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,1, "R7 "), // 14 idle 2
    mk(0,8'h00,0,0,0,3'b010,2'b00,0, 1,1,1, "R7 "), // 15 request restarts count
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,1, "R7 "), // 16 idle 1
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,1, "R7 "), // 17 idle 2
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,1, "R7 "), // 18 idle 3
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 3,0,1, "R7 "), // 19 idle 4 -> C4
    mk(1,8'h1C,0,0,0,3'b000,2'b00,1, 3,0,0, "R10"), // 20 suppress on, clear
    mk(0,8'h00,0,0,0,3'b001,2'b00,0, 1,1,0, "R8 "), // 21 popup, sts suppressed
    mk(1,8'h14,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 22 popup off, popdown bit on
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 23
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 24
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 25
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 26
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R5 "), // 27 still C2
    mk(0,8'h00,0,0,1,3'b000,2'b00,0, 0,1,0, "R11"), // 28 wake
    mk(1,8'h18,0,0,0,3'b000,2'b00,0, 0,1,0, "R1 "), // 29 popup only, suppress
    mk(0,8'h00,1,2,0,3'b000,2'b00,0, 2,0,0, "R12"), // 30 enter C3
    mk(0,8'h00,0,0,0,3'b001,2'b00,0, 1,1,0, "R6 "), // 31 popup
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R6 "), // 32
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R6 "), // 33
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R6 "), // 34
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R6 "), // 35
    mk(0,8'h00,0,0,0,3'b000,2'b00,0, 1,1,0, "R6 "), // 36 no popdown
    mk(0,8'h00,0,0,0,3'b001,2'b10,1, 1,1,1, "R10"), // 37 set beats clear, LPC (R9)
    mk(0,8'h00,1,3,0,3'b000,2'b00,0, 3,0,1, "R12"), // 38 command C4 from C2
    mk(0,8'h00,0,0,1,3'b001,2'b00,0, 0,1,1, "R11"), // 39 wake beats request
    mk(1,8'h0C,0,0,0,3'b000,2'b00,1, 0,1,0, "R10")  // 40 clear
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [7:0]        cfg_wr_data = '0;
  logic [7:0]        cfg_rd_data;
  logic              bm_sts_clr = 1'b0;
  logic              bm_sts;
  logic [N_MAIN-1:0] bm_req_main = '0;
  logic [N_LPC-1:0]  bm_req_lpc = '0;
  logic              wake_evt = 1'b0;
  logic              sleep_cmd_valid = 1'b0;
  logic [1:0]        sleep_cmd_state = '0;
  logic [1:0]        cstate;
  logic              bm_arb_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bm_popup_ctrl #(.N_MAIN(N_MAIN), .N_LPC(N_LPC), .IDLE_CYCLES(IDLE)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_en = 0; cfg_wr_data = '0; bm_sts_clr = 0; bm_req_main = '0;
    bm_req_lpc = '0; wake_evt = 0; sleep_cmd_valid = 0; sleep_cmd_state = '0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R13 reset values
    check("R13 level", {30'd0, cstate}, 32'd0);
    check("R13 arb", {31'd0, bm_arb_en}, 32'd1);
    check("R13 sts", {31'd0, bm_sts}, 32'd0);
    check("R1 reset cfg", {24'd0, cfg_rd_data}, 32'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      cfg_wr_en       = TBL[i].cw;
      cfg_wr_data     = TBL[i].cd;
      sleep_cmd_valid = TBL[i].cv;
      sleep_cmd_state = TBL[i].cs;
      wake_evt        = TBL[i].wk;
      bm_req_main     = TBL[i].mn;
      bm_req_lpc      = TBL[i].lp;
      bm_sts_clr      = TBL[i].cl;
      @(negedge clk);
      check($sformatf("%s row %0d", TBL[i].tag, i),
            {28'd0, cstate, bm_arb_en, bm_sts},
            {28'd0, TBL[i].es, TBL[i].ea, TBL[i].et});
    end
    idle_inputs();

    // R1 reserved bits read zero, scratchpad writable
    cfg_wr_en = 1; cfg_wr_data = 8'hFF;
    @(negedge clk);
    cfg_wr_en = 0;
    check("R1 cfg FF", {24'd0, cfg_rd_data}, 32'h7C);
    cfg_wr_en = 1; cfg_wr_data = 8'h61;
    @(negedge clk);
    cfg_wr_en = 0;
    check("R1 cfg scratch", {24'd0, cfg_rd_data}, 32'h60);

    // R13 reset mid-operation from C3 with sts set
    sleep_cmd_valid = 1; sleep_cmd_state = 2'd2; bm_req_lpc = 2'b01;
    @(negedge clk);
    idle_inputs();
    check("R12 enter C3 direct", {30'd0, cstate}, 32'd2);
    rst_n = 0;
    @(negedge clk);
    check("R13 level after reset", {30'd0, cstate}, 32'd0);
    check("R13 sts after reset", {31'd0, bm_sts}, 32'd0);
    check("R13 arb after reset", {31'd0, bm_arb_en}, 32'd1);
    check("R1 cfg after reset", {24'd0, cfg_rd_data}, 32'h00);
    rst_n = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule